// File: doc/BRIEF.md
# SPI Master with Status Flag Controller

This block is an 8-bit serial shift engine with a small register window on a synchronous host bus. It has three byte-wide registers: control, status and data. Writing the data register while the engine is master and idle starts a byte transfer. The byte goes out most significant bit first. The serial clock idles low, input is sampled on the rising clock edge and output changes on the falling edge. The serial clock runs at the system clock divided by `2*HALF_DIV`. The byte received on the input line is then readable from the data register.

The status register carries three flags.
- **Done** reports that a transfer has finished, and it can raise the interrupt line.
- **Collision** reports a data write that arrived while a byte was still shifting. The byte in flight continues unchanged and the new value is discarded.
- **Fault** reports a low level on the slave-select pin while the block is master and that pin is an input. On a fault the block drops master mode, aborts the transfer and releases the serial outputs.

Each flag clears only through a two-step sequence. First, a status read must see the flag set, which arms it. Then a later access to the right register clears it.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset the control, status and received-data registers read 0x00, `irq` is 0, and `sck_oe`, `mosi_oe` and `ss_oe` are 0.
- R2: In a transfer the byte appears on `mosi_o` MSB first. `mosi_o` is stable across each rising edge of `sck_o`, which idles low. The byte assembled from `miso_i` on the rising edges reads back from the data register (address 2).
- R3: The done flag (status bit 7) goes to 1 exactly `16*HALF_DIV` clock edges after the edge that accepts the starting data write. `irq` equals 1 while the done flag and control bit 7 (interrupt enable) are both 1.
- R4: The done flag clears only on a data-register read or write that follows a status read (address 1) that returned it as 1. A data access without such a prior read leaves it at 1.
- R5: A data write during a transfer sets the collision flag (status bit 6). The byte in flight is sent unchanged, the written value is lost, and the collision flag never drives `irq`.
- R6: The collision flag clears only on a data read or write that follows a status read that returned it as 1.
- R7: With control bit 4 (master) at 1, control bit 1 (pin direction) at 0 and `ss_i` low, the fault flag (status bit 4) is set at the next edge. On that edge the master bit clears, any transfer stops without setting the done flag, and `sck_oe` and `mosi_oe` go to 0.
- R8: The fault flag clears only on a control write (address 0) that follows a status read that returned it as 1. Data accesses leave it set.
- R9: When control bit 1 is 1, a low `ss_i` never sets the fault flag. This holds both with bit 0 at 1 and with bit 0 at 0.
- R10: Status bits 5 and 3..0 always read 0, and a write to the status register changes no flag.
- R11: With control bit 1 at 1, `ss_oe` is 1. If control bit 0 is 1, `ss_o` is low exactly while a transfer is in progress. If control bit 0 is 0, `ss_o` follows control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational from registers |
| irq | output | 1 | Interrupt request from the done flag |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable (master mode) |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out enable (master mode) |
| miso_i | input | 1 | Serial data in |
| ss_i | input | 1 | Slave-select pin input value |
| ss_o | output | 1 | Slave-select pin output value |
| ss_oe | output | 1 | Slave-select pin output enable |

## Verification
Register state and flags change on the clock edge that takes a strobe. Read data is combinational from registers, so the new state is visible on `bus_rdata` half a cycle after that edge. The bench drives strobes on falling edges and samples shortly after them.

The done flag is due `16*HALF_DIV` edges after the starting write. The bench checks that the status register still reads 0x00 one cycle before that point and reads 0x80 at it.

A fault lands on the first edge that sees `ss_i` low. The bench samples status, control and the output enables one falling edge after driving the pin. To observe state without arming any flag, the bench looks at `bus_rdata` with no read strobe.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  // control bit positions
  localparam int C_IE     = 7;
  localparam int C_MST    = 4;
  localparam int C_SSLVL  = 2;
  localparam int C_SSDIR  = 1;
  localparam int C_SSAUTO = 0;
  localparam logic [7:0] CTRL_MASK = 8'h97;

  // flag indices inside the flag vector
  localparam int NFLAG   = 3;
  localparam int F_DONE  = 0;
  localparam int F_COLL  = 1;
  localparam int F_FAULT = 2;

  // status bit positions
  localparam int S_DONE  = 7;
  localparam int S_COLL  = 6;
  localparam int S_FAULT = 4;
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          tick;

  assign tick      = run && (cnt_q == CNT_TOP);
  assign rise_tick = tick && !sck_q;
  assign fall_tick = tick && sck_q;
  assign sck       = sck_q;

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = !sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] tx_byte,
  input  logic             abort,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             miso,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] rx_byte
);
  localparam int BW = $clog2(WIDTH);
  localparam logic [BW-1:0] LAST_BIT = BW'(WIDTH - 1);

  logic [WIDTH-1:0] sh_q, sh_d, rx_q, rx_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic             busy_q, busy_d;
  logic             samp_q, samp_d;

  assign done    = busy_q && fall_tick && (bit_q == LAST_BIT) && !abort;
  assign busy    = busy_q;
  assign mosi    = sh_q[WIDTH-1];
  assign rx_byte = rx_q;

  always_comb begin
    sh_d   = sh_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    samp_d = samp_q;
    if (abort) begin
      busy_d = 1'b0;
      bit_d  = '0;
    end else if (start) begin
      sh_d   = tx_byte;
      bit_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (rise_tick) samp_d = miso;
      if (fall_tick) begin
        sh_d  = {sh_q[WIDTH-2:0], samp_q};
        bit_d = bit_q + 1'b1;
        if (bit_q == LAST_BIT) begin
          busy_d = 1'b0;
          rx_d   = {sh_q[WIDTH-2:0], samp_q};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
      samp_q <= samp_d;
    end
  end
endmodule

// File: rtl/spi_flag_regs.sv
module spi_flag_regs #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stat_rd,
  input  logic [NF-1:0] set_ev,
  input  logic [NF-1:0] clr_ev,
  output logic [NF-1:0] flag
);
  logic [NF-1:0] flag_q, flag_d, arm_q, arm_d;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic clr_fire;
    assign clr_fire = arm_q[i] && clr_ev[i];
    always_comb begin
      flag_d[i] = set_ev[i] || (flag_q[i] && !clr_fire);
      arm_d[i]  = flag_d[i] && ((arm_q[i] && !clr_fire) || (stat_rd && flag_q[i]));
    end
  end

  assign flag = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sck_o,
  output logic       sck_oe,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  input  logic       ss_i,
  output logic       ss_o,
  output logic       ss_oe
);
  logic [1:0]       rsync_q;
  logic             rst_core_n;
  logic [7:0]       ctrl_q, ctrl_d;
  logic             ctrl_wr, stat_rd, data_acc, data_wr;
  logic             fault_set, start, busy, done, shift_mosi;
  logic             sck, rise_tick, fall_tick;
  logic [7:0]       rx_byte, status;
  logic [NFLAG-1:0] set_ev, clr_ev, flg;

  // reset: asserted at once, released through two stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign stat_rd  = bus_rd && (bus_addr == A_STAT);
  assign data_wr  = bus_wr && (bus_addr == A_DATA);
  assign data_acc = (bus_rd || bus_wr) && (bus_addr == A_DATA);

  assign fault_set = ctrl_q[C_MST] && !ctrl_q[C_SSDIR] && !ss_i;
  assign start     = data_wr && !busy && ctrl_q[C_MST] && !fault_set;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr)   ctrl_d = bus_wdata & CTRL_MASK;
    if (fault_set) ctrl_d[C_MST] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ctrl_q <= '0;
    else             ctrl_q <= ctrl_d;
  end

  spi_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk(clk), .rst_n(rst_core_n), .run(busy),
    .sck(sck), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  spi_shift_core #(.WIDTH(8)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .start(start), .tx_byte(bus_wdata),
    .abort(fault_set), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .miso(miso_i), .mosi(shift_mosi), .busy(busy), .done(done),
    .rx_byte(rx_byte)
  );

  always_comb begin
    set_ev          = '0;
    clr_ev          = '0;
    set_ev[F_DONE]  = done;
    set_ev[F_COLL]  = data_wr && busy;
    set_ev[F_FAULT] = fault_set;
    clr_ev[F_DONE]  = data_acc;
    clr_ev[F_COLL]  = data_acc;
    clr_ev[F_FAULT] = ctrl_wr;
  end

  spi_flag_regs #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_core_n), .stat_rd(stat_rd),
    .set_ev(set_ev), .clr_ev(clr_ev), .flag(flg)
  );

  always_comb begin
    status          = '0;
    status[S_DONE]  = flg[F_DONE];
    status[S_COLL]  = flg[F_COLL];
    status[S_FAULT] = flg[F_FAULT];
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = status;
      A_DATA:  bus_rdata = rx_byte;
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = flg[F_DONE] && ctrl_q[C_IE];
  assign sck_oe  = ctrl_q[C_MST];
  assign sck_o   = sck;
  assign mosi_oe = ctrl_q[C_MST];
  assign mosi_o  = shift_mosi;
  assign ss_oe   = ctrl_q[C_SSDIR];
  assign ss_o    = ctrl_q[C_SSAUTO] ? !busy : ctrl_q[C_SSLVL];
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic       irq,
  input logic       sck_oe,
  input logic       ss_oe,
  input logic       busy,
  input logic [2:0] flg
);
  // R3
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[0]) |-> ($past(busy) && !busy));

  // R4
  done_clear_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg[0]) |-> $past((bus_addr == 2'd2) && (bus_rd || bus_wr)));

  // R6
  coll_clear_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg[1]) |-> $past((bus_addr == 2'd2) && (bus_rd || bus_wr)));

  // R8
  fault_clear_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg[2]) |-> $past((bus_addr == 2'd0) && bus_wr));

  // R7
  fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[2]) |-> (!sck_oe && !busy));

  // R9
  fault_pin_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[2]) |-> !$past(ss_oe));

  // R5
  irq_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flg[0]);

  // R10
  stat_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> ((bus_rdata & 8'h2F) == 8'h00));
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .irq(irq), .sck_oe(sck_oe),
  .ss_oe(ss_oe), .busy(busy), .flg(flg)
);

// File: tb/sim_spi_flag_ctrl.sv
`timescale 1ns/100ps
module sim_spi_flag_ctrl;
  localparam int HD   = 2;
  localparam int XFER = 16 * HD;

  logic       clk, rst_n;
  logic [1:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_i, ss_i, ss_o, ss_oe;
  logic       inv;
  logic [7:0] cap, rd;
  int         n_chk, n_fail;
  bit         finished;

  spi_flag_ctrl #(.HALF_DIV(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .ss_i(ss_i), .ss_o(ss_o),
    .ss_oe(ss_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = !clk;

  assign miso_i = mosi_o ^ inv;
  always @(posedge sck_o) cap <= {cap[6:0], mosi_o};

  // {tx byte, invert loopback, expected rx byte}
  localparam logic [16:0] VEC [4] = '{
    {8'hA5, 1'b0, 8'hA5},
    {8'h3C, 1'b1, 8'hC3},
    {8'h80, 1'b0, 8'h80},
    {8'h01, 1'b1, 8'hFE}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = '0; inv = 1'b0; ss_i = 1'b1; cap = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(2'd0, rd); check("R1 ctrl", rd, 8'h00);
    peek(2'd1, rd); check("R1 status", rd, 8'h00);
    peek(2'd2, rd); check("R1 data", rd, 8'h00);
    check("R1 irq/oe", {4'h0, irq, sck_oe, mosi_oe, ss_oe}, 8'h00);

    // vector table: master, pin output driven as slave select
    bwrite(2'd0, 8'h13);
    for (int i = 0; i < 4; i++) begin
      inv = VEC[i][8];
      bwrite(2'd2, VEC[i][16:9]);
      check("R11 ss low busy", {7'h0, ss_o}, 8'h00);
      repeat (XFER - 1) @(negedge clk);
      peek(2'd1, rd); check("R3 not yet", rd, 8'h00);
      @(negedge clk);
      peek(2'd1, rd); check("R3 done", rd, 8'h80);
      check("R2 mosi order", cap, VEC[i][16:9]);
      check("R11 ss high idle", {6'h0, ss_oe, ss_o}, 8'h03);
      bread(2'd2, rd);
      peek(2'd1, rd); check("R4 unarmed keeps", rd, 8'h80);
      bread(2'd1, rd);
      bread(2'd2, rd); check("R2 rx data", rd, VEC[i][7:0]);
      peek(2'd1, rd); check("R4 cleared", rd, 8'h00);
    end

    // R3 interrupt and R10 status write ignored
    bwrite(2'd0, 8'h93);
    inv = 1'b0;
    bwrite(2'd2, 8'h5A);
    repeat (XFER) @(negedge clk);
    check("R3 irq", {7'h0, irq}, 8'h01);
    bwrite(2'd1, 8'hFF);
    peek(2'd1, rd); check("R10 write ignored", rd, 8'h80);
    bread(2'd1, rd);
    bwrite(2'd2, 8'h00);
    check("R3 irq cleared", {7'h0, irq}, 8'h00);
    repeat (XFER + 2) @(negedge clk);
    bread(2'd1, rd);
    bread(2'd2, rd);

    // R5 collision: byte in flight kept, write lost, no irq
    bwrite(2'd2, 8'hA5);
    repeat (8) @(negedge clk);
    bwrite(2'd2, 8'h3C);
    peek(2'd1, rd); check("R5 coll set", rd, 8'h40);
    check("R5 no irq", {7'h0, irq}, 8'h00);
    bread(2'd2, rd);
    peek(2'd1, rd); check("R6 unarmed keeps", rd, 8'h40);
    repeat (XFER) @(negedge clk);
    check("R5 byte kept", cap, 8'hA5);
    peek(2'd2, rd); check("R5 rx kept", rd, 8'hA5);
    bread(2'd1, rd); check("R10 both flags", rd, 8'hC0);
    bread(2'd2, rd);
    peek(2'd1, rd); check("R6 cleared", rd, 8'h00);

    // R7 fault during transfer
    bwrite(2'd0, 8'h11);
    bwrite(2'd2, 8'hF0);
    repeat (5) @(negedge clk);
    ss_i = 1'b0;
    @(negedge clk);
    peek(2'd1, rd); check("R7 fault set", rd, 8'h10);
    peek(2'd0, rd); check("R7 master cleared", rd, 8'h01);
    check("R7 outputs off", {6'h0, sck_oe, mosi_oe}, 8'h00);
    ss_i = 1'b1;
    repeat (XFER + 4) @(negedge clk);
    peek(2'd1, rd); check("R7 no done", rd, 8'h10);

    // R8 clearing sequence
    bwrite(2'd0, 8'h01);
    peek(2'd1, rd); check("R8 unarmed ctrl", rd, 8'h10);
    bread(2'd1, rd);
    bread(2'd2, rd);
    peek(2'd1, rd); check("R8 data no clear", rd, 8'h10);
    bwrite(2'd0, 8'h00);
    peek(2'd1, rd); check("R8 cleared", rd, 8'h00);

    // R9 suppression with pin as output, R11 level control
    bwrite(2'd0, 8'h13);
    ss_i = 1'b0;
    repeat (3) @(negedge clk);
    peek(2'd1, rd); check("R9 ss output", rd, 8'h00);
    bwrite(2'd0, 8'h16);
    repeat (3) @(negedge clk);
    peek(2'd1, rd); check("R9 gp output", rd, 8'h00);
    check("R11 level high", {6'h0, ss_oe, ss_o}, 8'h03);
    bwrite(2'd0, 8'h12);
    check("R11 level low", {6'h0, ss_oe, ss_o}, 8'h02);
    ss_i = 1'b1;
    bwrite(2'd0, 8'h00);

    finish_run();
  end
endmodule